// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel of a timer subsystem. It watches one of two 16-bit free-running timer counts and drives one output pin from a set/reset latch. A 3-bit mode field chooses what the pin does: it can be held low, set, cleared or toggled on a match, made into one pulse or a train of pulses between two compare values, or made into a pulse-width modulated signal. The PWM form can also be cut off by an active-low fault pin.

Each timer comes with its own period-match strobe. A select bit picks which timer and which strobe the channel uses. The primary compare value marks the leading edge and the secondary value marks the trailing edge. In the PWM modes the secondary value is the duty, and it takes effect at the next period strobe. The channel raises a one-cycle event flag on the compare event of the current mode. It also holds a sticky fault indication that only a change of the mode field clears.

All outputs are registered. An input pattern present before clock edge n shows at the outputs just after edge n.

Top module: `ocmp_channel`

## Requirements
- R1: While reset is asserted, and just after it is released, `oc_pin`, `oc_evt` and `oc_flt` are 0. The stored mode is 000.
- R2: When `tb_sel` is 0, the timer count and period strobe come from `tmr_a`/`tmr_a_prd`. When it is 1, they come from `tmr_b`/`tmr_b_prd`. The other timer has no effect.
- R3: If `oc_mode` differs from the mode stored at the previous edge, then at the next edge the pin takes its entry level, the flag is 0 and the fault bit is cleared. The entry level is high for mode 010 and low for every other mode. The mode is then stored. In mode 000 the pin stays low and no flag is raised.
- R4: Modes 001, 010 and 011 act when the selected timer equals `cmp_pri`. Mode 001 sets the pin, mode 010 clears it, and mode 011 inverts it. Each such match also pulses `oc_evt`.
- R5: Mode 100 makes one pulse. The pin goes high on the first primary match. It goes low on the next secondary match, which also pulses `oc_evt`. After that, matches have no effect until the mode is entered again.
- R6: In mode 101, every secondary match drives the pin low and pulses `oc_evt`. A primary match that is not also a secondary match drives the pin high, so the secondary match wins when the two coincide.
- R7: On every selected period strobe, in any mode, the active duty register loads `cmp_sec`. In modes 110 and 111 the strobe also sets the pin high, or low if the loaded value is 0, and pulses `oc_evt`. When there is no strobe, the pin goes low when the timer equals the active duty.
- R8: In mode 111, a low `oc_flt_n` drives the pin low at the next edge and sets `oc_flt`. While `oc_flt` is set the pin stays low, though strobes still pulse `oc_evt` and load the duty. Only a mode change clears `oc_flt`. In mode 110 the fault pin is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_a | input | 16 | Count of timer A |
| tmr_a_prd | input | 1 | Period-match strobe of timer A |
| tmr_b | input | 16 | Count of timer B |
| tmr_b_prd | input | 1 | Period-match strobe of timer B |
| tb_sel | input | 1 | Time base select (0 = A, 1 = B) |
| cmp_pri | input | 16 | Primary (leading-edge) compare value |
| cmp_sec | input | 16 | Secondary (trailing-edge / duty) compare value |
| oc_mode | input | 3 | Mode field |
| oc_flt_n | input | 1 | Active-low fault input |
| oc_pin | output | 1 | Compare output pin |
| oc_evt | output | 1 | One-cycle event flag |
| oc_flt | output | 1 | Sticky fault status |

## Verification
Two timers run with different periods, so a wrong choice of time base shows up as edges at the wrong counts. The select bit is randomized for each segment, and it is sometimes flipped in the middle of a segment. Compare values are random within the period. Some cases are forced: both compare values equal, a duty of 0, and a value the timer never reaches. These separate the priority of secondary over primary, the case of a pulse that never starts, and the case of a PWM output that stays low. Mode changes come back to back and in the middle of a pulse, which tests the entry levels and the re-arming of the single pulse. Short fault bursts in modes 110 and 111 separate a fault that is ignored from one that latches and holds.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

   typedef enum logic [2:0] {
      OCM_OFF  = 3'b000,
      OCM_SET  = 3'b001,
      OCM_CLR  = 3'b010,
      OCM_TGL  = 3'b011,
      OCM_ONE  = 3'b100,
      OCM_CONT = 3'b101,
      OCM_PWM  = 3'b110,
      OCM_PWMF = 3'b111
   } ocm_mode_e;

   // Pin level forced when a mode is entered
   function automatic logic ocm_entry_level(ocm_mode_e m);
      return (m == OCM_CLR);
   endfunction

   function automatic logic ocm_is_pwm(ocm_mode_e m);
      return (m == OCM_PWM) || (m == OCM_PWMF);
   endfunction

endpackage

// File: rtl/ocmp_tbase_sel.sv
module ocmp_tbase_sel #(
   parameter int TMR_W  = 16,
   parameter int NUM_TB = 2,
   localparam int SEL_W = (NUM_TB > 1) ? $clog2(NUM_TB) : 1
) (
   input  logic [NUM_TB-1:0][TMR_W-1:0] tb_cnt,
   input  logic [NUM_TB-1:0]            tb_prd,
   input  logic [SEL_W-1:0]             sel,
   output logic [TMR_W-1:0]             cnt,
   output logic                         prd
);
   if (NUM_TB < 1) begin : g_bad_num
      $error("ocmp_tbase_sel: NUM_TB must be at least 1");
   end

   if (NUM_TB == 1) begin : g_single
      assign cnt = tb_cnt[0];
      assign prd = tb_prd[0];
   end else begin : g_multi
      always_comb begin
         cnt = tb_cnt[0];
         prd = tb_prd[0];
         for (int i = 1; i < NUM_TB; i++) begin
            if (int'(sel) == i) begin
               cnt = tb_cnt[i];
               prd = tb_prd[i];
            end
         end
      end
   end
endmodule

// File: rtl/ocmp_match.sv
module ocmp_match #(
   parameter int TMR_W = 16
) (
   input  logic [TMR_W-1:0] cnt,
   input  logic [TMR_W-1:0] cmp_pri,
   input  logic [TMR_W-1:0] cmp_sec,
   input  logic [TMR_W-1:0] duty,
   output logic             pri_hit,
   output logic             sec_hit,
   output logic             duty_hit
);
   if (TMR_W < 2) begin : g_bad_w
      $error("ocmp_match: TMR_W must be at least 2");
   end

   assign pri_hit  = (cnt == cmp_pri);
   assign sec_hit  = (cnt == cmp_sec);
   assign duty_hit = (cnt == duty);
endmodule

// File: rtl/ocmp_duty_reg.sv
module ocmp_duty_reg #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             prd,
   input  logic [TMR_W-1:0] duty_next,
   output logic [TMR_W-1:0] duty,
   output logic             next_zero
);
   always_ff @(posedge clk) begin
      if (!rst_n)   duty <= '0;
      else if (prd) duty <= duty_next;
   end

   assign next_zero = (duty_next == '0);

   // R7
   duty_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prd |=> (duty == $past(duty_next)));
endmodule

// File: rtl/ocmp_out_ctl.sv
module ocmp_out_ctl
   import ocmp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  ocm_mode_e mode,
   input  logic      mode_chg,
   input  logic      pri_hit,
   input  logic      sec_hit,
   input  logic      duty_hit,
   input  logic      prd,
   input  logic      duty_zero,
   input  logic      flt_n,
   output logic      pin,
   output logic      evt,
   output logic      flt
);
   logic done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin  <= 1'b0;
         evt  <= 1'b0;
         flt  <= 1'b0;
         done <= 1'b0;
      end else if (mode_chg) begin
         pin  <= ocm_entry_level(mode);
         evt  <= 1'b0;
         flt  <= 1'b0;
         done <= 1'b0;
      end else begin
         evt <= 1'b0;
         unique case (mode)
            OCM_OFF: pin <= 1'b0;
            OCM_SET: begin
               if (pri_hit) pin <= 1'b1;
               evt <= pri_hit;
            end
            OCM_CLR: begin
               if (pri_hit) pin <= 1'b0;
               evt <= pri_hit;
            end
            OCM_TGL: begin
               if (pri_hit) pin <= ~pin;
               evt <= pri_hit;
            end
            OCM_ONE: begin
               if (!done) begin
                  if (!pin && pri_hit) begin
                     pin <= 1'b1;
                  end else if (pin && sec_hit) begin
                     pin  <= 1'b0;
                     done <= 1'b1;
                     evt  <= 1'b1;
                  end
               end
            end
            OCM_CONT: begin
               if (sec_hit) begin
                  pin <= 1'b0;
                  evt <= 1'b1;
               end else if (pri_hit) begin
                  pin <= 1'b1;
               end
            end
            OCM_PWM, OCM_PWMF: begin
               evt <= prd;
               if (mode == OCM_PWMF && (flt || !flt_n)) begin
                  pin <= 1'b0;
                  flt <= 1'b1;
               end else if (prd) begin
                  pin <= !duty_zero;
               end else if (duty_hit) begin
                  pin <= 1'b0;
               end
            end
            default: pin <= 1'b0;
         endcase
      end
   end

   // R3
   entry_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |=> (pin == ($past(mode) == OCM_CLR)) && !evt && !flt);

   // R8
   flt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flt |-> !pin);

   // R8
   flt_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_chg && mode == OCM_PWMF && !flt_n) |=> (flt && !pin));

   // R5
   one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !mode_chg && mode == OCM_ONE) |=> (!pin && !evt));

   // R3
   off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == OCM_OFF) |=> !pin && !evt);
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
   import ocmp_pkg::*;
#(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TMR_W-1:0] tmr_a,
   input  logic             tmr_a_prd,
   input  logic [TMR_W-1:0] tmr_b,
   input  logic             tmr_b_prd,
   input  logic             tb_sel,
   input  logic [TMR_W-1:0] cmp_pri,
   input  logic [TMR_W-1:0] cmp_sec,
   input  logic [2:0]       oc_mode,
   input  logic             oc_flt_n,
   output logic             oc_pin,
   output logic             oc_evt,
   output logic             oc_flt
);
   localparam int NUM_TB = 2;

   logic [NUM_TB-1:0][TMR_W-1:0] tb_cnt;
   logic [NUM_TB-1:0]            tb_prd;
   logic [TMR_W-1:0]             cnt;
   logic                         prd;
   logic [TMR_W-1:0]             duty;
   logic                         duty_zero;
   logic                         pri_hit, sec_hit, duty_hit;
   ocm_mode_e                    mode_now, mode_q;
   logic                         mode_chg;

   assign tb_cnt   = {tmr_b, tmr_a};
   assign tb_prd   = {tmr_b_prd, tmr_a_prd};
   assign mode_now = ocm_mode_e'(oc_mode);
   assign mode_chg = (mode_now != mode_q);

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= OCM_OFF;
      else        mode_q <= mode_now;
   end

   ocmp_tbase_sel #(.TMR_W(TMR_W), .NUM_TB(NUM_TB)) u_sel (
      .tb_cnt (tb_cnt),
      .tb_prd (tb_prd),
      .sel    (tb_sel),
      .cnt    (cnt),
      .prd    (prd)
   );

   ocmp_duty_reg #(.TMR_W(TMR_W)) u_duty (
      .clk       (clk),
      .rst_n     (rst_n),
      .prd       (prd),
      .duty_next (cmp_sec),
      .duty      (duty),
      .next_zero (duty_zero)
   );

   ocmp_match #(.TMR_W(TMR_W)) u_match (
      .cnt      (cnt),
      .cmp_pri  (cmp_pri),
      .cmp_sec  (cmp_sec),
      .duty     (duty),
      .pri_hit  (pri_hit),
      .sec_hit  (sec_hit),
      .duty_hit (duty_hit)
   );

   ocmp_out_ctl u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode_now),
      .mode_chg  (mode_chg),
      .pri_hit   (pri_hit),
      .sec_hit   (sec_hit),
      .duty_hit  (duty_hit),
      .prd       (prd),
      .duty_zero (duty_zero),
      .flt_n     (oc_flt_n),
      .pin       (oc_pin),
      .evt       (oc_evt),
      .flt       (oc_flt)
   );

   // R7
   pwm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_chg && ocm_is_pwm(mode_now) && prd && cmp_sec == '0) |=> !oc_pin && oc_evt);

   // R4
   set_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_chg && mode_now == OCM_SET && pri_hit) |=> oc_pin && oc_evt);
endmodule

// File: tb/tb_ocmp_channel.sv
`timescale 1ns/1ps
module tb_ocmp_channel;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] tmr_a, tmr_b, cmp_pri, cmp_sec;
   logic        tmr_a_prd, tmr_b_prd, tb_sel, oc_flt_n;
   logic [2:0]  oc_mode;
   logic        oc_pin, oc_evt, oc_flt;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   localparam int PA = 24, PB = 17;

   // bench-side expected state
   logic       e_pin, e_evt, e_flt, e_done;
   logic [2:0] e_mode;
   logic [15:0] e_duty;
   int ca, cb;

   always #2 clk = ~clk;

   ocmp_channel dut (.*);

   function automatic string req_tag(logic [2:0] m, logic s);
      string r;
      case (m)
         3'd0: r = "R3";
         3'd1, 3'd2, 3'd3: r = "R4";
         3'd4: r = "R5";
         3'd5: r = "R6";
         3'd6: r = "R7";
         default: r = "R8";
      endcase
      return s ? {r, " R2"} : r;
   endfunction

   task automatic check(string tag);
      n_chk++;
      if (oc_pin !== e_pin || oc_evt !== e_evt || oc_flt !== e_flt) begin
         n_fail++;
         $display("FAIL %s: pin/evt/flt actual %b%b%b expected %b%b%b (mode %b)",
                  tag, oc_pin, oc_evt, oc_flt, e_pin, e_evt, e_flt, e_mode);
      end
   endtask

   // expected outputs after the coming edge, from the requirements
   task automatic model_step();
      logic [15:0] t; logic p, ph, sh, dh;
      t  = tb_sel ? tmr_b : tmr_a;
      p  = tb_sel ? tmr_b_prd : tmr_a_prd;
      ph = (t == cmp_pri); sh = (t == cmp_sec); dh = (t == e_duty);
      e_evt = 0;
      if (oc_mode != e_mode) begin // R3
         e_pin = (oc_mode == 3'b010); e_flt = 0; e_done = 0;
      end else begin
         case (oc_mode)
            3'd0: e_pin = 0;
            3'd1: begin if (ph) e_pin = 1; e_evt = ph; end
            3'd2: begin if (ph) e_pin = 0; e_evt = ph; end
            3'd3: begin if (ph) e_pin = ~e_pin; e_evt = ph; end
            3'd4: if (!e_done) begin
               if (!e_pin && ph) e_pin = 1;
               else if (e_pin && sh) begin e_pin = 0; e_done = 1; e_evt = 1; end
            end
            3'd5: if (sh) begin e_pin = 0; e_evt = 1; end else if (ph) e_pin = 1;
            default: begin
               e_evt = p;
               if (oc_mode == 3'd7 && (e_flt || !oc_flt_n)) begin e_pin = 0; e_flt = 1; end
               else if (p) e_pin = (cmp_sec != 0);
               else if (dh) e_pin = 0;
            end
         endcase
      end
      if (p) e_duty = cmp_sec;
      e_mode = oc_mode;
   endtask

   task automatic drive_timers();
      tmr_a = 16'(ca); tmr_a_prd = (ca == PA - 1);
      tmr_b = 16'(cb); tmr_b_prd = (cb == PB - 1);
   endtask

   // one clock: check previous result, apply inputs, predict
   task automatic cycle();
      drive_timers();
      model_step();
      @(negedge clk);
      check(req_tag(e_mode, tb_sel));
      ca = (ca + 1) % PA; cb = (cb + 1) % PB;
   endtask

   initial begin
      void'($urandom(32'd1234));
      rst_n = 0; tb_sel = 0; cmp_pri = 0; cmp_sec = 0; oc_mode = 0; oc_flt_n = 1;
      ca = 0; cb = 0; drive_timers();
      e_pin = 0; e_evt = 0; e_flt = 0; e_done = 0; e_mode = 0; e_duty = 0;
      repeat (3) @(negedge clk);
      check("R1 reset");
      rst_n = 1;

      // directed: mode 101 with equal compares, secondary wins (R6)
      oc_mode = 3'd5; cmp_pri = 16'd5; cmp_sec = 16'd5;
      repeat (50) cycle();
      // directed: PWM duty zero keeps pin low (R7)
      oc_mode = 3'd6; cmp_sec = 16'd0;
      repeat (50) cycle();
      // directed: single pulse, then retrigger by mode change (R5)
      oc_mode = 3'd4; cmp_pri = 16'd3; cmp_sec = 16'd9;
      repeat (60) cycle();
      oc_mode = 3'd0; cycle();
      oc_mode = 3'd4; repeat (30) cycle();
      // directed: fault in 110 ignored, in 111 latched (R8)
      oc_mode = 3'd6; cmp_sec = 16'd10; repeat (30) cycle();
      oc_flt_n = 0; repeat (3) cycle(); oc_flt_n = 1; repeat (30) cycle();
      oc_mode = 3'd7; repeat (30) cycle();
      oc_flt_n = 0; cycle(); oc_flt_n = 1; repeat (40) cycle();
      oc_mode = 3'd6; cycle(); oc_mode = 3'd7; repeat (30) cycle();
      // directed: timer B selected (R2)
      tb_sel = 1; oc_mode = 3'd3; cmp_pri = 16'd20; repeat (40) cycle(); // never reached on B
      cmp_pri = 16'd4; repeat (40) cycle();

      // constrained random segments
      for (int s = 0; s < 120; s++) begin
         int len;
         oc_mode = 3'($urandom_range(0, 7));
         tb_sel  = 1'($urandom_range(0, 1));
         cmp_pri = 16'($urandom_range(0, PA));
         cmp_sec = ($urandom_range(0, 5) == 0) ? cmp_pri : 16'($urandom_range(0, PA));
         len = $urandom_range(5, 90);
         for (int c = 0; c < len; c++) begin
            oc_flt_n = ($urandom_range(0, 40) != 0);
            if ($urandom_range(0, 60) == 0) tb_sel = ~tb_sel;
            if ($urandom_range(0, 50) == 0) cmp_sec = 16'($urandom_range(0, PA));
            cycle();
         end
         oc_flt_n = 1;
      end
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule